// File: doc/BRIEF.md
# SPI-Mode SD Command Responder

This block is the card-side byte engine that frames SD commands on an SPI link. Every SPI byte exchange is one accepted input byte on a valid/ready port, and it returns exactly one output byte one clock later. The block gathers a six-byte command frame: an index byte, four argument bytes sent most significant first, and a check byte that is not verified. It then places the index and the argument on a request port to a backend card model and waits for that model's answer. The answer carries a success flag, a flag saying the short answer had the expected length, a 32-bit native card status word and a 32-bit long answer.

From that answer the block builds the SPI-format reply. It folds the native status into a 16-bit SPI status word and chooses how many reply bytes to send from the command index. It sends one filler byte before the reply and one trailer byte after it. On the trailer byte it either hands off to a data-read engine by pulsing `rd_start`, or returns to idle. Commands that leave the card busy never hand off.

The controller has six named states. IDLE leaves for ARG on any input other than 0xFF. ARG collects four argument bytes and leaves for EXEC when the check byte arrives. EXEC stalls input and leaves for FILL when the backend answers. FILL moves to RESP after one byte. RESP moves to TAIL after the last reply byte. TAIL returns to IDLE after one byte.

Top module: `sd_spi_cmd_resp`

## Requirements
- R1: In IDLE an input byte 0xFF is a null command: it returns 0xFF and the block stays in IDLE.
- R2: Any other byte in IDLE starts a frame, and its low 6 bits are the command index. The next four bytes form `req_arg` with the first byte in bits 31:24. The sixth byte is ignored, and accepting it raises `req_valid`, with `req_index` and `req_arg` held steady until `rsp_valid`.
- R3: Every accepted byte yields exactly one `out_valid` pulse on the following cycle, and no output appears without an accepted byte. Bytes with no reply content return 0xFF. `in_ready` is low while a backend request is outstanding.
- R4: After the backend answers, the next byte returns the filler 0xFF, and the reply starts on the byte after that. Input values during FILL, RESP and TAIL are ignored.
- R5: For any command other than 8 and 58, a failed request (`rsp_ok`=0) or an unexpected length (`rsp_fmt_ok`=0) gives the single reply byte 0x04.
- R6: Commands 8 and 58 with `rsp_ok`=1 reply with five bytes: 0x01, then `rsp_long[31:24]`, `[23:16]`, `[15:8]`, `[7:0]`. `rsp_fmt_ok` does not affect this.
- R7: Command 13 replies with status word bits 15:8 and then bits 7:0. All other successful status commands reply with bits 15:8 only.
- R8: Status word bit 8 is set when `rsp_status[12:9]` is below 4. Bit 14 is set when any of status word bits 7:0 is set. Bit 15 is always 0.
- R9: Status word bits copy these native status bits: [13]→9, [22]→10, [23]→11, [28]→12, [30]→13, [25]→0, [24] or [15]→1, [19]→2, [20]→3, [21]→4, [26]→5, [27]→6, [31] or [16]→7.
- R10: After the last reply byte exactly one trailer byte returns 0xFF, and the block then returns to IDLE. For successful status commands 28, 29 and 38, `rd_start` stays low whatever the value of `data_pending`.
- R11: For every other command, `rd_start` pulses for one cycle with the trailer byte's output when `data_pending` is high at the trailer byte. Otherwise it stays low.
- R12: A synchronous `rst` aborts any frame, drops `out_valid`, `req_valid` and `rd_start`, raises `in_ready` and returns to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte offered |
| in_ready | output | 1 | Block can accept an input byte |
| in_byte | input | 8 | Byte received from the SPI host |
| out_valid | output | 1 | One-cycle pulse: reply byte for the previously accepted input |
| out_byte | output | 8 | Byte to shift back to the host |
| req_valid | output | 1 | Backend request pending |
| req_index | output | 6 | Command index |
| req_arg | output | 32 | Command argument |
| rsp_valid | input | 1 | Backend answer present |
| rsp_ok | input | 1 | Backend executed the command |
| rsp_fmt_ok | input | 1 | Short answer had the expected length |
| rsp_status | input | 32 | Native card status |
| rsp_long | input | 32 | Long answer for commands 8 and 58 |
| data_pending | input | 1 | Backend has read data ready |
| rd_start | output | 1 | One-cycle handoff to the data-read phase |

## Verification
The bench builds the block with its default parameters: a 6-bit index and a 4-byte argument, so the reply buffer holds five bytes. These values bring every reply length within reach: the five-byte long reply, the two-byte status reply and the single-byte reply. They also reach the full 32-bit argument ordering. A backend that answers after a delay exercises the EXEC stall. Random and all-ones native status words reach every bit of the status mapping.

// File: rtl/sdspi_pkg.sv
package sdspi_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARG,
        ST_EXEC,
        ST_FILL,
        ST_RESP,
        ST_TAIL
    } sdspi_state_e;

    localparam logic [7:0] NULL_BYTE    = 8'hFF;
    localparam logic [7:0] ILLEGAL_BYTE = 8'h04;
    localparam logic [7:0] LONG_LEAD    = 8'h01;

    // command indices with special reply handling
    localparam int CMD_IF_COND  = 8;
    localparam int CMD_OCR      = 58;
    localparam int CMD_STATUS   = 13;
    localparam int CMD_BUSY_A   = 28;
    localparam int CMD_BUSY_B   = 29;
    localparam int CMD_BUSY_C   = 38;

    // native card status bit positions
    localparam int CS_RANGE     = 31;
    localparam int CS_ADDR      = 30;
    localparam int CS_ESEQ      = 28;
    localparam int CS_EPARAM    = 27;
    localparam int CS_WPV       = 26;
    localparam int CS_LOCKED    = 25;
    localparam int CS_LOCKFAIL  = 24;
    localparam int CS_CRC       = 23;
    localparam int CS_ILLEGAL   = 22;
    localparam int CS_ECC       = 21;
    localparam int CS_CC        = 20;
    localparam int CS_GEN       = 19;
    localparam int CS_OVERWR    = 16;
    localparam int CS_WPSKIP    = 15;
    localparam int CS_ERESET    = 13;
    localparam int CS_STATE_HI  = 12;
    localparam int CS_STATE_LO  = 9;

    // SPI status word bit positions
    localparam int SW_LOCKED    = 0;
    localparam int SW_WPERASE   = 1;
    localparam int SW_GEN       = 2;
    localparam int SW_CC        = 3;
    localparam int SW_ECC       = 4;
    localparam int SW_WPV       = 5;
    localparam int SW_EPARAM    = 6;
    localparam int SW_RANGE     = 7;
    localparam int SW_IDLE      = 8;
    localparam int SW_ERESET    = 9;
    localparam int SW_ILLEGAL   = 10;
    localparam int SW_CRC       = 11;
    localparam int SW_ESEQ      = 12;
    localparam int SW_ADDR      = 13;
    localparam int SW_PARAM     = 14;

endpackage

// File: rtl/sdspi_frame_capture.sv
module sdspi_frame_capture
    import sdspi_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int ARG_BYTES = 4,
    localparam int ARG_W    = 8 * ARG_BYTES,
    localparam int CNT_W    = $clog2(ARG_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             shift,
    input  logic [7:0]       byte_in,
    output logic [IDX_W-1:0] index,
    output logic [ARG_W-1:0] arg,
    output logic             args_done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            index <= '0;
            arg   <= '0;
        end else if (start) begin
            cnt_q <= '0;
            index <= byte_in[IDX_W-1:0];
        end else if (shift && !args_done) begin
            cnt_q <= cnt_q + CNT_W'(1);
            arg   <= (arg << 8) | ARG_W'(byte_in);
        end
    end

    assign args_done = (cnt_q == CNT_W'(ARG_BYTES));

    // R2: the argument byte counter never passes the argument length
    assert_arg_count_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(ARG_BYTES));

endmodule

// File: rtl/sdspi_status_map.sv
module sdspi_status_map
    import sdspi_pkg::*;
(
    input  logic [31:0] card_status,
    output logic [15:0] spi_word
);

    logic unused_status_bits;
    assign unused_status_bits = ^{card_status[29], card_status[18:17], card_status[14],
                                  card_status[8:0]};

    always_comb begin
        spi_word = '0;
        spi_word[SW_IDLE]    = (card_status[CS_STATE_HI:CS_STATE_LO] < 4'd4);
        spi_word[SW_ERESET]  = card_status[CS_ERESET];
        spi_word[SW_ILLEGAL] = card_status[CS_ILLEGAL];
        spi_word[SW_CRC]     = card_status[CS_CRC];
        spi_word[SW_ESEQ]    = card_status[CS_ESEQ];
        spi_word[SW_ADDR]    = card_status[CS_ADDR];
        spi_word[SW_LOCKED]  = card_status[CS_LOCKED];
        spi_word[SW_WPERASE] = card_status[CS_LOCKFAIL] | card_status[CS_WPSKIP];
        spi_word[SW_GEN]     = card_status[CS_GEN];
        spi_word[SW_CC]      = card_status[CS_CC];
        spi_word[SW_ECC]     = card_status[CS_ECC];
        spi_word[SW_WPV]     = card_status[CS_WPV];
        spi_word[SW_EPARAM]  = card_status[CS_EPARAM];
        spi_word[SW_RANGE]   = card_status[CS_RANGE] | card_status[CS_OVERWR];
        spi_word[SW_PARAM]   = |spi_word[7:0];
    end

endmodule

// File: rtl/sdspi_resp_build.sv
module sdspi_resp_build
    import sdspi_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int LONG_BYTES = 4,
    localparam int RESP_MAX  = LONG_BYTES + 1,
    localparam int CNT_W     = $clog2(RESP_MAX + 1)
) (
    input  logic [IDX_W-1:0]              index,
    input  logic                          ok,
    input  logic                          fmt_ok,
    input  logic [31:0]                   card_status,
    input  logic [8*LONG_BYTES-1:0]       long_rsp,
    output logic [RESP_MAX-1:0][7:0]      bytes,
    output logic [CNT_W-1:0]              len,
    output logic                          busy
);

    logic [15:0] spi_word;
    logic        is_long;
    logic        is_busy_cmd;

    sdspi_status_map u_map (
        .card_status (card_status),
        .spi_word    (spi_word)
    );

    assign is_long     = (int'(index) == CMD_IF_COND) || (int'(index) == CMD_OCR);
    assign is_busy_cmd = (int'(index) == CMD_BUSY_A) || (int'(index) == CMD_BUSY_B) ||
                         (int'(index) == CMD_BUSY_C);

    always_comb begin
        bytes = '1;
        len   = CNT_W'(1);
        busy  = 1'b0;
        if (!ok) begin
            bytes[0] = ILLEGAL_BYTE;
        end else if (is_long) begin
            bytes[0] = LONG_LEAD;
            for (int k = 0; k < LONG_BYTES; k++) begin
                bytes[k+1] = long_rsp[8*(LONG_BYTES-1-k) +: 8];
            end
            len = CNT_W'(RESP_MAX);
        end else if (!fmt_ok) begin
            bytes[0] = ILLEGAL_BYTE;
        end else begin
            bytes[0] = spi_word[15:8];
            busy     = is_busy_cmd;
            if (int'(index) == CMD_STATUS) begin
                bytes[1] = spi_word[7:0];
                len      = CNT_W'(2);
            end
        end
    end

endmodule

// File: rtl/sd_spi_cmd_resp.sv
module sd_spi_cmd_resp
    import sdspi_pkg::*;
#(
    parameter int IDX_W      = 6,
    parameter int ARG_BYTES  = 4,
    parameter int LONG_BYTES = 4,
    localparam int ARG_W     = 8 * ARG_BYTES,
    localparam int RESP_MAX  = LONG_BYTES + 1,
    localparam int CNT_W     = $clog2(RESP_MAX + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [7:0]              in_byte,
    output logic                    out_valid,
    output logic [7:0]              out_byte,
    output logic                    req_valid,
    output logic [IDX_W-1:0]        req_index,
    output logic [ARG_W-1:0]        req_arg,
    input  logic                    rsp_valid,
    input  logic                    rsp_ok,
    input  logic                    rsp_fmt_ok,
    input  logic [31:0]             rsp_status,
    input  logic [8*LONG_BYTES-1:0] rsp_long,
    input  logic                    data_pending,
    output logic                    rd_start
);

    sdspi_state_e state_q, state_d;

    logic                     accept;
    logic                     args_done;
    logic [RESP_MAX-1:0][7:0] build_bytes;
    logic [CNT_W-1:0]         build_len;
    logic                     build_busy;
    logic [RESP_MAX-1:0][7:0] resp_q;
    logic [CNT_W-1:0]         len_q;
    logic [CNT_W-1:0]         pos_q;
    logic                     busy_q;
    logic                     last_resp;

    assign in_ready  = (state_q != ST_EXEC);
    assign accept    = in_valid && in_ready;
    assign req_valid = (state_q == ST_EXEC);
    assign last_resp = (pos_q == len_q - CNT_W'(1));

    sdspi_frame_capture #(
        .IDX_W     (IDX_W),
        .ARG_BYTES (ARG_BYTES)
    ) u_capture (
        .clk       (clk),
        .rst       (rst),
        .start     (accept && state_q == ST_IDLE && in_byte != NULL_BYTE),
        .shift     (accept && state_q == ST_ARG),
        .byte_in   (in_byte),
        .index     (req_index),
        .arg       (req_arg),
        .args_done (args_done)
    );

    sdspi_resp_build #(
        .IDX_W      (IDX_W),
        .LONG_BYTES (LONG_BYTES)
    ) u_build (
        .index       (req_index),
        .ok          (rsp_ok),
        .fmt_ok      (rsp_fmt_ok),
        .card_status (rsp_status),
        .long_rsp    (rsp_long),
        .bytes       (build_bytes),
        .len         (build_len),
        .busy        (build_busy)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && in_byte != NULL_BYTE) state_d = ST_ARG;
            ST_ARG:  if (accept && args_done)            state_d = ST_EXEC;
            ST_EXEC: if (rsp_valid)                      state_d = ST_FILL;
            ST_FILL: if (accept)                         state_d = ST_RESP;
            ST_RESP: if (accept && last_resp)            state_d = ST_TAIL;
            ST_TAIL: if (accept)                         state_d = ST_IDLE;
            default:                                     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // outputs and reply datapath
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_byte  <= NULL_BYTE;
            rd_start  <= 1'b0;
            resp_q    <= '1;
            len_q     <= CNT_W'(1);
            pos_q     <= '0;
            busy_q    <= 1'b0;
        end else begin
            out_valid <= accept;
            rd_start  <= accept && state_q == ST_TAIL && !busy_q && data_pending;
            if (accept) begin
                out_byte <= (state_q == ST_RESP) ? resp_q[pos_q] : NULL_BYTE;
            end
            if (state_q == ST_EXEC && rsp_valid) begin
                resp_q <= build_bytes;
                len_q  <= build_len;
                busy_q <= build_busy;
                pos_q  <= '0;
            end else if (state_q == ST_RESP && accept) begin
                pos_q <= pos_q + CNT_W'(1);
            end
        end
    end

    // R3: one reply byte per accepted byte, on the next cycle
    assert_one_out_R3: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);
    assert_no_spurious_out_R3: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);

    // R1: a null byte in idle answers 0xFF and keeps the block idle
    assert_null_idle_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && accept && in_byte == NULL_BYTE)
        |=> (state_q == ST_IDLE && out_byte == NULL_BYTE));

    // R2: the request stays steady until answered
    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid)
        |=> (req_valid && $stable(req_arg) && $stable(req_index)));

    // R4: the byte after execution is the filler
    assert_filler_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && accept) |=> (out_byte == NULL_BYTE));

    // R7: reply length is one of the legal sizes
    assert_len_legal_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RESP)
        |-> (len_q == CNT_W'(1) || len_q == CNT_W'(2) || len_q == CNT_W'(RESP_MAX)));

    // R10: the trailer byte of a busy command never hands off
    assert_busy_no_handoff_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_TAIL && accept && busy_q) |=> !rd_start);

    // R11: a handoff only comes with the trailer byte's output
    assert_handoff_with_tail_R11: assert property (@(posedge clk) disable iff (rst)
        rd_start |-> (out_valid && out_byte == NULL_BYTE && state_q == ST_IDLE));

endmodule

// File: tb/tb_sd_spi_cmd_resp.sv
module tb_sd_spi_cmd_resp;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_byte = 8'h00;
    logic        out_valid;
    logic [7:0]  out_byte;
    logic        req_valid;
    logic [5:0]  req_index;
    logic [31:0] req_arg;
    logic        rsp_valid = 1'b0;
    logic        rsp_ok = 1'b0;
    logic        rsp_fmt_ok = 1'b0;
    logic [31:0] rsp_status = '0;
    logic [31:0] rsp_long = '0;
    logic        data_pending = 1'b0;
    logic        rd_start;

    always #4 clk = ~clk;

    sd_spi_cmd_resp dut (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_ready (in_ready), .in_byte (in_byte),
        .out_valid (out_valid), .out_byte (out_byte),
        .req_valid (req_valid), .req_index (req_index), .req_arg (req_arg),
        .rsp_valid (rsp_valid), .rsp_ok (rsp_ok), .rsp_fmt_ok (rsp_fmt_ok),
        .rsp_status (rsp_status), .rsp_long (rsp_long),
        .data_pending (data_pending), .rd_start (rd_start)
    );

    int          total = 0;
    int          bad = 0;
    int          rd_cnt = 0;
    int          cyc = 0;
    int          wait_c = 0;
    logic [7:0]  exp_q[$];
    string       cur_req = "R1";
    logic [5:0]  exp_idx;
    logic [31:0] exp_arg;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // reference comparison on every clock: each output byte against the model queue
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "output without accepted byte", out_byte, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(out_byte == e, cur_req, "output byte", out_byte, e);
                end
            end
            if (rd_start) rd_cnt++;
        end
    end

    // behavioural backend: answers two cycles after a request appears
    always @(negedge clk) begin
        if (rst) begin
            rsp_valid = 1'b0;
            wait_c = 0;
        end else if (rsp_valid) begin
            rsp_valid = 1'b0;
        end else if (req_valid) begin
            if (wait_c == 0) begin
                check(req_index == exp_idx, "R2", "request index", req_index, exp_idx);
                check(req_arg == exp_arg, "R2", "request argument", req_arg, exp_arg);
                check(!in_ready, "R3", "in_ready during request", in_ready, 0);
            end
            if (wait_c == 2) begin
                rsp_valid = 1'b1;
                wait_c = 0;
            end else begin
                wait_c++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send(input logic [7:0] b, input logic [7:0] e);
        exp_q.push_back(e);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [15:0] ref_word(input logic [31:0] s);
        logic [15:0] w;
        w = 16'h0000;
        if (s[12:9] < 4) w = w | 16'h0100;
        if (s[13]) w = w | 16'h0200;
        if (s[22]) w = w | 16'h0400;
        if (s[23]) w = w | 16'h0800;
        if (s[28]) w = w | 16'h1000;
        if (s[30]) w = w | 16'h2000;
        if (s[25]) w = w | 16'h0001;
        if (s[24] || s[15]) w = w | 16'h0002;
        if (s[19]) w = w | 16'h0004;
        if (s[20]) w = w | 16'h0008;
        if (s[21]) w = w | 16'h0010;
        if (s[26]) w = w | 16'h0020;
        if (s[27]) w = w | 16'h0040;
        if (s[31] || s[16]) w = w | 16'h0080;
        if ((w & 16'h00FF) != 0) w = w | 16'h4000;
        return w;
    endfunction

    task automatic do_cmd(input string req, input logic [1:0] top_bits, input int idx,
                          input logic [31:0] arg, input bit ok, input bit fmt,
                          input logic [31:0] st, input logic [31:0] lng, input bit pend);
        logic [7:0] resp[$];
        logic [15:0] w;
        bit busy;
        int rd_before;
        busy = 0;
        w = ref_word(st);
        if ((idx == 8 || idx == 58) && ok) begin
            resp.push_back(8'h01);
            resp.push_back(lng[31:24]);
            resp.push_back(lng[23:16]);
            resp.push_back(lng[15:8]);
            resp.push_back(lng[7:0]);
        end else if (!ok || !fmt) begin
            resp.push_back(8'h04);
        end else begin
            resp.push_back(w[15:8]);
            if (idx == 13) resp.push_back(w[7:0]);
            busy = (idx == 28 || idx == 29 || idx == 38);
        end
        cur_req    = req;
        exp_idx    = idx[5:0];
        exp_arg    = arg;
        rsp_ok     = ok;
        rsp_fmt_ok = fmt;
        rsp_status = st;
        rsp_long   = lng;
        data_pending = pend;
        rd_before  = rd_cnt;
        send({top_bits, idx[5:0]}, 8'hFF);
        send(arg[31:24], 8'hFF);
        send(arg[23:16], 8'hFF);
        send(arg[15:8], 8'hFF);
        send(arg[7:0], 8'hFF);
        send(8'h95, 8'hFF);
        send(8'h4C, 8'hFF);                     // R4 filler, input ignored
        foreach (resp[i]) send(8'h4C, resp[i]);
        send(8'h00, 8'hFF);                     // R10 trailer, input ignored
        @(negedge clk);
        check(rd_cnt - rd_before == ((pend && !busy) ? 1 : 0),
              busy ? "R10" : "R11", "handoff pulses", rd_cnt - rd_before,
              (pend && !busy) ? 1 : 0);
        check(exp_q.size() == 0, "R3", "outstanding expected bytes", exp_q.size(), 0);
        data_pending = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        exp_q.delete();
        check(out_valid == 1'b0, "R12", "out_valid in reset", out_valid, 0);
        check(req_valid == 1'b0, "R12", "req_valid in reset", req_valid, 0);
        check(rd_start == 1'b0, "R12", "rd_start in reset", rd_start, 0);
        check(in_ready == 1'b1, "R12", "in_ready in reset", in_ready, 1);
        rst = 1'b0;
    endtask

    initial begin
        do_reset();

        cur_req = "R1";
        for (int i = 0; i < 3; i++) send(8'hFF, 8'hFF);
        @(negedge clk);
        check(exp_q.size() == 0, "R1", "null bytes answered", exp_q.size(), 0);

        // status commands
        do_cmd("R7", 2'b01, 0, 32'h00000000, 1, 1, 32'h00000000, 32'h0, 0);
        do_cmd("R9", 2'b01, 13, 32'h12345678, 1, 1, 32'hFFFFFFFF, 32'h0, 0);
        do_cmd("R8", 2'b10, 13, 32'hA5A50F0F, 1, 1, 32'h00000800, 32'h0, 0);
        do_cmd("R11", 2'b01, 17, 32'h00000200, 1, 1, 32'h00000900, 32'h0, 1);
        do_cmd("R11", 2'b01, 18, 32'h00000400, 1, 1, 32'h00000800, 32'h0, 0);

        // long replies
        do_cmd("R6", 2'b01, 8, 32'h000001AA, 1, 1, 32'h0, 32'h000001AA, 0);
        do_cmd("R6", 2'b01, 58, 32'h00000000, 1, 0, 32'h0, 32'hC0FF8000, 1);

        // failures
        do_cmd("R5", 2'b01, 55, 32'hDEADBEEF, 0, 1, 32'h0, 32'h0, 0);
        do_cmd("R5", 2'b01, 17, 32'h00000001, 1, 0, 32'h0, 32'h0, 1);
        do_cmd("R5", 2'b01, 8, 32'h000001AA, 0, 1, 32'h0, 32'h12345678, 0);

        // busy commands
        do_cmd("R10", 2'b01, 38, 32'h0, 1, 1, 32'h00000000, 32'h0, 1);
        do_cmd("R10", 2'b01, 28, 32'h11223344, 1, 1, 32'h00400000, 32'h0, 1);
        do_cmd("R10", 2'b01, 29, 32'h55667788, 1, 1, 32'h00000000, 32'h0, 1);

        // random status words
        for (int i = 0; i < 16; i++) begin
            do_cmd("R9", 2'b01, 13, $urandom, 1, 1, $urandom, 32'h0, i[0]);
        end

        // reset mid-frame
        cur_req = "R12";
        send(8'h51, 8'hFF);
        send(8'h00, 8'hFF);
        do_reset();
        cur_req = "R12";
        send(8'hFF, 8'hFF);
        @(negedge clk);
        check(exp_q.size() == 0, "R12", "idle after reset", exp_q.size(), 0);
        do_cmd("R12", 2'b01, 13, 32'hCAFEF00D, 1, 1, 32'h80010000, 32'h0, 0);

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule